// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Bus

This block is a two-wire serial bus target (SMBus/I2C electrical and framing conventions) that exposes a small bank of byte-wide configuration registers. A controller reaches one register per transfer. In a byte write it sends the target address, a command byte and one data byte. In a byte read it sends the target address and a command byte, then a repeated START, the address again with the read bit set, and it clocks out one data byte before it answers NACK and STOP. A command byte whose top bit is 1 carries the register offset in its low seven bits.

Register writes pass through a two-level protection scheme. Bit 0 of register 0 opens the bank, but a new value of that bit only governs transfers that begin after the one that wrote it. Bit 7 of register 0 is a one-shot seal that freezes every register until reset. A blocked write is still acknowledged byte by byte and then silently dropped.

Register 0 also carries the frequency-select field, loaded from four strap pins at reset, and a software spread-enable bit. That bit reads back as its strap pin and is ORed with that strap to form the spread-enable output. The SDA pad is open-drain: the block only asserts an enable that pulls the line low.

The protocol engine has these states and transitions. IDLE waits for a START. ADDR shifts in the address byte and goes to ADDR_ACK on a match or WAIT on a mismatch. ADDR_ACK moves to CMD for a write or to RDATA for a read. CMD shifts in the command and goes to CMD_ACK. CMD_ACK moves to WDATA for a byte command or to WAIT for a block command. WDATA shifts in data and goes to WDATA_ACK, which leads to WAIT. RDATA shifts out eight bits and goes to RDATA_ACK, which leads to WAIT. WAIT ignores the bus. A START in any state enters ADDR, and a STOP in any state enters IDLE.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register 0 equals {3'b000, fs_strap, 1'b0}, all other registers are 0, fs_sel equals fs_strap, spread_en equals ss_strap and sda_oe is 0.
- R2: The target acknowledges an address byte equal to SLV_ADDR with the R/W bit in bit 0. Any other address gets no ACK, and no further byte of that transfer is acknowledged.
- R3: When writes are open, a byte write with command 1ooooooo stores the data byte in register ooooooo, and cfg_q byte ooooooo shows it.
- R4: A byte read with a repeated START returns the addressed register MSB first on SDA, in the eight SCL clocks that follow the address ACK.
- R5: From reset, writes are closed. Every byte is still acknowledged, but only register 0 bit 0 changes. A 1 written there opens all registers from the next START on, not within the same transfer.
- R6: After register 0 bit 0 is written back to 0, later transfers can change only that bit. All other bits and registers keep their values.
- R7: Writing 1 to register 0 bit 7 in an open transfer seals the bank. After that, no register changes until reset, and all write bytes are still acknowledged.
- R8: Reading register 0 returns ss_strap in bit 6. spread_en equals ss_strap OR the stored bit 6, and fs_sel equals register 0 bits [4:1].
- R9: A command byte with bit 7 = 0 is acknowledged. It changes no register, and the data bytes that follow it are not acknowledged.
- R10: A STOP in the middle of a byte aborts the transfer without writing, and the next transfer works normally.
- R11: An offset at or above NUM_REGS reads as 8'h00, and writes to it are acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset, also samples the straps |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| fs_strap | input | 4 | Frequency-select strap pins, loaded at reset |
| ss_strap | input | 1 | Spread-enable strap pin |
| fs_sel | output | 4 | Frequency-select value, register 0 bits [4:1] |
| spread_en | output | 1 | Effective spread enable |
| cfg_q | output | 8*NUM_REGS | All register bytes, byte i at bits [8i+7:8i] |

## Verification
Both bus lines pass through two synchronising flops and one edge register. Each SCL edge is therefore seen three clock cycles after it appears on the pin, and the state register takes the new state on that cycle. So an ACK or a read data bit appears on sda_oe three cycles after the SCL falling edge that precedes it. A register write reaches cfg_q, fs_sel and spread_en three to four cycles after the falling edge that ends the eighth data bit. The bench drives each half SCL period for twenty clock cycles. It samples SDA at the end of the SCL high phase, and it checks register outputs only after the STOP, well clear of every update.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFF_W  = BYTE_W - 1;
    localparam int unsigned CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_WAIT
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_bit
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_s, sda_s, scl_d, sda_d;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SDA moving while SCL stays high marks a frame boundary
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign sda_bit   = sda_s;
endmodule

// File: rtl/smb_proto_fsm.sv
`timescale 1ns/1ps
module smb_proto_fsm
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_bit,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [OFF_W-1:0]  cur_off,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output smb_state_e        state
);
    smb_state_e        st_n;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q, blk_q;
    logic [OFF_W-1:0]  off_q;
    logic              byte_done, rx_state, ack_state;

    assign byte_done = scl_fall && (bitcnt == CNT_W'(BYTE_W));
    assign rx_state  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
    assign ack_state = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) || (state == ST_WDATA_ACK);

    // next-state logic
    always_comb begin
        st_n = state;
        if (start_evt) begin
            st_n = ST_ADDR;
        end else if (stop_evt) begin
            st_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      st_n = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  st_n = (shreg[7:1] == SLV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) st_n = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) st_n = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) st_n = blk_q ? ST_WAIT : ST_WDATA;
                ST_WDATA:     if (byte_done) st_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) st_n = ST_WAIT;
                ST_RDATA:     if (scl_fall && bitcnt == CNT_W'(BYTE_W - 1)) st_n = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) st_n = ST_WAIT;
                ST_WAIT:      st_n = ST_WAIT;
                default:      st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // shift register, bit counter and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            blk_q  <= 1'b0;
            off_q  <= '0;
        end else if (start_evt || stop_evt) begin
            bitcnt <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_bit};
                bitcnt <= bitcnt + 1'b1;
            end
            if (state == ST_ADDR && st_n == ST_ADDR_ACK)
                rw_q <= shreg[0];
            if (state == ST_CMD && st_n == ST_CMD_ACK) begin
                blk_q <= ~shreg[BYTE_W-1];
                if (shreg[BYTE_W-1])
                    off_q <= shreg[OFF_W-1:0];
            end
            if (ack_state && scl_fall) begin
                bitcnt <= '0;
                if (state == ST_ADDR_ACK && rw_q)
                    shreg <= rd_byte;
            end
            if (state == ST_RDATA && scl_fall) begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_stb  = (state == ST_WDATA) && byte_done && !start_evt && !stop_evt;
        wr_data = shreg;
        cur_off = off_q;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_evt,
    input  logic                       wr_stb,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [OFF_W-1:0]           cur_off,
    input  logic [3:0]                 fs_strap,
    input  logic                       ss_strap,
    output logic [BYTE_W-1:0]          rd_byte,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_q,
    output logic                       sealed,
    output logic [3:0]                 fs_sel,
    output logic                       spread_en
);
    localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned BIT_WE = 0;
    localparam int unsigned BIT_SS = 6;
    localparam int unsigned BIT_LK = 7;

    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic              wr_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs[i] <= (i == 0) ? {3'b000, fs_strap, 1'b0} : '0;
            wr_open <= 1'b0;
        end else begin
            // permission follows the enable bit as it stood when the transfer began
            if (start_evt)
                wr_open <= regs[0][BIT_WE] & ~regs[0][BIT_LK];
            if (wr_stb && !regs[0][BIT_LK]) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (cur_off == OFF_W'(i)) begin
                        if (wr_open)
                            regs[i] <= wr_data;
                        else if (i == 0)
                            regs[0][BIT_WE] <= wr_data[BIT_WE];
                    end
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign cfg_q[g*BYTE_W +: BYTE_W] = regs[g];
        end
    endgenerate

    always_comb begin
        if (cur_off >= OFF_W'(NUM_REGS))
            rd_byte = '0;
        else if (cur_off == '0)
            rd_byte = {regs[0][BIT_LK], ss_strap, regs[0][BIT_SS-1:0]};
        else
            rd_byte = regs[cur_off[IDX_W-1:0]];
    end

    assign sealed    = regs[0][BIT_LK];
    assign fs_sel    = regs[0][4:1];
    assign spread_en = ss_strap | regs[0][BIT_SS];
endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0]  SLV_ADDR    = 7'h2C,
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [3:0]                 fs_strap,
    input  logic                       ss_strap,
    output logic [3:0]                 fs_sel,
    output logic                       spread_en,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_q
);
    logic              scl_rise, scl_fall, start_evt, stop_evt, sda_bit;
    logic              wr_stb, sealed;
    logic [BYTE_W-1:0] wr_data, rd_byte;
    logic [OFF_W-1:0]  cur_off;
    smb_state_e        state;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(sda_bit)
    );

    smb_proto_fsm #(.SLV_ADDR(SLV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(sda_bit),
        .rd_byte(rd_byte), .cur_off(cur_off), .wr_stb(wr_stb),
        .wr_data(wr_data), .sda_oe(sda_oe), .state(state)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .wr_stb(wr_stb),
        .wr_data(wr_data), .cur_off(cur_off), .fs_strap(fs_strap),
        .ss_strap(ss_strap), .rd_byte(rd_byte), .cfg_q(cfg_q),
        .sealed(sealed), .fs_sel(fs_sel), .spread_en(spread_en)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
`timescale 1ns/1ps
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input smb_state_e                 state,
    input logic                       stop_evt,
    input logic                       wr_stb,
    input logic                       sealed,
    input logic                       ss_strap,
    input logic                       spread_en,
    input logic [3:0]                 fs_sel,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_q
);
    // R3: registers change only on a write strobe from the protocol engine
    p_change_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(wr_stb));

    // R7: the seal never drops once set
    p_seal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sealed) |-> sealed);

    // R7: a sealed bank holds every register
    p_sealed_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed && $past(sealed)) |-> $stable(cfg_q));

    // R8: spread output combines strap and stored bit; frequency field follows register 0
    p_spread_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en == (ss_strap | cfg_q[6])) && (fs_sel == cfg_q[4:1]));

    // R10: a STOP returns the engine to idle
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .stop_evt(stop_evt),
    .wr_stb(wr_stb), .sealed(sealed), .ss_strap(ss_strap),
    .spread_en(spread_en), .fs_sel(fs_sel), .cfg_q(cfg_q)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;
    localparam int   NREG = 8;
    localparam int   HALF = 20;
    localparam logic [6:0] ADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] fs_strap = 4'hA;
    logic ss_strap = 1'b0;
    logic sda_oe, spread_en;
    logic [3:0] fs_sel;
    logic [NREG*8-1:0] cfg_q;
    logic sda_line;
    int checks = 0;
    int fails = 0;

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    smb_cfg_slave #(.SLV_ADDR(ADDR), .NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .fs_strap(fs_strap), .ss_strap(ss_strap), .fs_sel(fs_sel),
        .spread_en(spread_en), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_half();
        scl = 1'b1;   wait_half();
        sda_m = 1'b0; wait_half();
        scl = 1'b0;   wait_half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_half();
        scl = 1'b1;   wait_half();
        sda_m = 1'b1; wait_half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_half();
            scl = 1'b1;   wait_half();
            scl = 1'b0;   wait_half();
        end
        sda_m = 1'b1; wait_half();
        scl = 1'b1;   wait_half();
        ack = ~sda_line;
        scl = 1'b0;   wait_half();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wait_half();
            scl = 1'b1; wait_half();
            b = {b[6:0], sda_line};
            scl = 1'b0;
        end
        sda_m = 1'b1; wait_half();   // NACK
        scl = 1'b1;   wait_half();
        scl = 1'b0;   wait_half();
    endtask

    task automatic smb_write(input logic [7:0] cmd, input logic [7:0] data,
                             input string req, input logic exp_data_ack);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk({req, " addr ack"}, {7'd0, a}, 8'd1);
        send_byte(cmd, a);          chk({req, " cmd ack"}, {7'd0, a}, 8'd1);
        send_byte(data, a);         chk({req, " data ack"}, {7'd0, a}, {7'd0, exp_data_ack});
        bus_stop();
    endtask

    task automatic smb_read(input logic [7:0] cmd, output logic [7:0] data);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R2 read addr ack", {7'd0, a}, 8'd1);
        send_byte(cmd, a);          chk("R4 read cmd ack", {7'd0, a}, 8'd1);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R4 read addr ack", {7'd0, a}, 8'd1);
        recv_byte(data);
        bus_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 reg0", cfg_q[7:0], 8'h14);
        chk("R1 reg3", cfg_q[31:24], 8'h00);
        chk("R1 fs_sel", {4'd0, fs_sel}, 8'h0A);
        chk("R1 spread_en", {7'd0, spread_en}, 8'h00);
        chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_read_reg0();
        logic [7:0] d;
        smb_read(8'h80, d);
        chk("R4 read reg0", d, 8'h14);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({7'h2D, 1'b0}, a); chk("R2 mismatch addr nack", {7'd0, a}, 8'd0);
        send_byte(8'h80, a);         chk("R2 mismatch cmd nack", {7'd0, a}, 8'd0);
        send_byte(8'hFF, a);         chk("R2 mismatch data nack", {7'd0, a}, 8'd0);
        bus_stop();
        chk("R2 reg0 unchanged", cfg_q[7:0], 8'h14);
    endtask

    task automatic t_closed_and_deferred();
        logic [7:0] d;
        smb_write(8'h83, 8'h5C, "R5 closed write", 1'b1);
        chk("R5 reg3 discarded", cfg_q[31:24], 8'h00);
        smb_write(8'h80, 8'hF1, "R5 enable write", 1'b1);
        chk("R5 only bit0 changes", cfg_q[7:0], 8'h15);
        smb_write(8'h83, 8'h5C, "R3 open write", 1'b1);
        chk("R3 reg3 stored", cfg_q[31:24], 8'h5C);
        smb_read(8'h83, d);
        chk("R4 read reg3", d, 8'h5C);
    endtask

    task automatic t_spread_fs();
        logic [7:0] d;
        smb_write(8'h80, 8'h4B, "R8 write reg0", 1'b1);
        chk("R8 reg0 stored", cfg_q[7:0], 8'h4B);
        chk("R8 fs_sel", {4'd0, fs_sel}, 8'h05);
        chk("R8 spread from stored bit", {7'd0, spread_en}, 8'h01);
        smb_read(8'h80, d);
        chk("R8 bit6 reads strap", d, 8'h0B);
    endtask

    task automatic t_reclose();
        logic [7:0] d;
        smb_write(8'h80, 8'h4A, "R6 clear enable", 1'b1);
        chk("R6 reg0 after clear", cfg_q[7:0], 8'h4A);
        smb_write(8'h82, 8'h77, "R6 blocked write", 1'b1);
        chk("R6 reg2 unchanged", cfg_q[23:16], 8'h00);
        smb_write(8'h80, 8'h00, "R6 bit0-only write", 1'b1);
        chk("R6 reg0 other bits kept", cfg_q[7:0], 8'h4A);
        smb_read(8'h82, d);
        chk("R6 read reg2", d, 8'h00);
        smb_write(8'h80, 8'h01, "R6 reopen", 1'b1);
        chk("R6 reg0 bit0 only", cfg_q[7:0], 8'h4B);
        smb_write(8'h82, 8'h77, "R6 open write", 1'b1);
        chk("R6 reg2 stored", cfg_q[23:16], 8'h77);
    endtask

    task automatic t_block_cmd();
        smb_write(8'h02, 8'h11, "R9 block command", 1'b0);
        chk("R9 reg2 unchanged", cfg_q[23:16], 8'h77);
        chk("R9 reg0 unchanged", cfg_q[7:0], 8'h4B);
    endtask

    task automatic t_stop_abort();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h82, a);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0; wait_half();
            scl = 1'b1;   wait_half();
            scl = 1'b0;   wait_half();
        end
        bus_stop();
        chk("R10 reg2 after abort", cfg_q[23:16], 8'h77);
        smb_read(8'h82, d);
        chk("R10 read after abort", d, 8'h77);
    endtask

    task automatic t_out_of_range();
        logic [7:0] d;
        smb_write(8'h90, 8'hAA, "R11 far write", 1'b1);
        chk("R11 reg0 kept", cfg_q[7:0], 8'h4B);
        chk("R11 reg2 kept", cfg_q[23:16], 8'h77);
        smb_read(8'h90, d);
        chk("R11 far read", d, 8'h00);
    endtask

    task automatic t_seal();
        logic [7:0] d;
        smb_write(8'h80, 8'h8B, "R7 seal write", 1'b1);
        chk("R7 reg0 sealed", cfg_q[7:0], 8'h8B);
        chk("R7 spread off", {7'd0, spread_en}, 8'h00);
        smb_write(8'h81, 8'h33, "R7 sealed write", 1'b1);
        chk("R7 reg1 frozen", cfg_q[15:8], 8'h00);
        smb_write(8'h80, 8'h00, "R7 sealed reg0 write", 1'b1);
        chk("R7 reg0 frozen", cfg_q[7:0], 8'h8B);
        smb_read(8'h80, d);
        chk("R7 read sealed reg0", d, 8'h8B);
        ss_strap = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 spread from strap", {7'd0, spread_en}, 8'h01);
        smb_read(8'h80, d);
        chk("R8 bit6 follows strap", d, 8'hCB);
    endtask

    task automatic t_reset_unseals();
        logic [7:0] d;
        ss_strap = 1'b0;
        fs_strap = 4'h3;
        do_reset();
        chk("R1 reg0 after reset", cfg_q[7:0], 8'h06);
        chk("R1 fs_sel after reset", {4'd0, fs_sel}, 8'h03);
        smb_write(8'h80, 8'h01, "R7 unsealed enable", 1'b1);
        chk("R7 reg0 bit0 after reset", cfg_q[7:0], 8'h07);
        smb_write(8'h81, 8'h33, "R7 write after reset", 1'b1);
        chk("R7 reg1 after reset", cfg_q[15:8], 8'h33);
        smb_read(8'h81, d);
        chk("R4 read reg1", d, 8'h33);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_read_reg0();
        t_wrong_addr();
        t_closed_and_deferred();
        t_spread_fs();
        t_reclose();
        t_block_cmd();
        t_stop_abort();
        t_out_of_range();
        t_seal();
        t_reset_unseals();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule